// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for each incoming frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address, which is presented once per frame together with a one-cycle strobe. The decision comes out one clock later as a registered accept bit and a reason code.

The filter is configured through a plain 32-bit write port that holds five registers. A mode register holds three control bits: promiscuous, broadcast reject and hash checking for unicast frames. Two registers hold the station address. Two more registers form a 64-bit multicast hash table.

A multicast frame is kept when the table bit selected by its address is set. That bit is chosen by the top six bits of the Ethernet CRC-32 taken over the six destination bytes, and the CRC is computed inside the block. The destination address is carried on `rx_da` with the first byte on the wire in bits 47:40 and the last in bits 7:0.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: While reset is high and after it is released, `dec_valid` and `dec_accept` are 0 and `dec_reason` is 0. All configuration registers reset to zero, so the station address resets to 00:00:00:00:00:00.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` in the register named by `cfg_sel`. The select codes are as follows.
  - Select 0 is the mode register. Bit 3 is broadcast reject, bit 4 is unicast hash checking and bit 5 is promiscuous.
  - Select 1 holds station bytes 2, 3, 4 and 5 in bits 31:24, 23:16, 15:8 and 7:0.
  - Select 2 holds station byte 0 in bits 15:8 and byte 1 in bits 7:0.
  - Select 3 holds hash bits 0..31 and select 4 holds hash bits 32..63.
- R3: For a strobe `rx_da_valid` in cycle n, `dec_valid` is 1 in cycle n+1 only, and the decision is held until the next strobe.
- R4: A unicast frame (bit 40 of `rx_da` clear) whose address equals the station address is accepted with reason 1 (exact).
- R5: For a multicast frame (bit 40 set, not all ones), the hash index is bits 31:26 of the CRC-32. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least significant bit first starting with byte 0, and has no final inversion. Index bit 5 picks the register (0 for select 3, 1 for select 4) and bits 4:0 pick the bit. The frame is accepted with reason 2 if that bit is set, and rejected otherwise.
- R6: A broadcast frame (all 48 bits set) is accepted with reason 3 when mode bit 3 is clear, and rejected when it is set.
- R7: With mode bit 5 set, every frame is accepted with reason 4, including broadcasts while broadcast reject is set.
- R8: With mode bit 4 set, a unicast frame that misses the station address is accepted with reason 2 when its hash bit is set. An exact match still reports reason 1.
- R9: With mode bit 4 clear, a unicast frame that misses the station address is rejected whatever the hash table holds.
- R10: A configuration write in the same cycle as a strobe does not affect that frame. The frame is judged on the values held before the write, and the next frame sees the new value.
- R11: The reason codes are 0 none, 1 exact, 2 hash, 3 broadcast and 4 promiscuous. `dec_accept` is 1 exactly when the reason is not 0.
- R12: Writes with select codes 5, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Write data |
| rx_da_valid | input | 1 | Destination address strobe, one cycle per frame |
| rx_da | input | 48 | Destination address, first wire byte in bits 47:40 |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | Reason for the decision |

## Verification
A configuration write and an address strobe can land in the same cycle. That matters most when the write flips promiscuous mode, broadcast reject or the hash word the frame's index selects. The bench forces this collision on purpose: it drives a write and a strobe on the same edge, predicts the decision from its shadow copy of the registers as they stood before the write, and then sends a second frame to confirm that the new value has taken effect. Random traffic mixes exact hits, broadcasts, multicasts and stray unicasts under random modes and tables, and every decision is compared with a reference model in the bench.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CFG_DW   = 32;
  localparam int CFG_SELW = 3;

  localparam logic [CFG_SELW-1:0] SEL_MODE   = 3'd0;
  localparam logic [CFG_SELW-1:0] SEL_STN_LO = 3'd1;
  localparam logic [CFG_SELW-1:0] SEL_STN_HI = 3'd2;
  localparam logic [CFG_SELW-1:0] SEL_HASH0  = 3'd3;

  localparam int MODE_BC_REJ  = 3;
  localparam int MODE_UC_HASH = 4;
  localparam int MODE_PROMISC = 5;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_EXACT   = 3'd1,
    RSN_HASH    = 3'd2,
    RSN_BCAST   = 3'd3,
    RSN_PROMISC = 3'd4
  } rxf_reason_e;

  typedef struct packed {
    logic promisc;
    logic uc_hash;
    logic bc_rej;
  } rxf_mode_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 64,
  parameter int ADDR_W    = 48
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_SELW-1:0]   cfg_sel,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  output rxf_mode_t             mode,
  output logic [ADDR_W-1:0]     station,
  output logic [HASH_BITS-1:0]  hash_tbl
);
  localparam int HASH_WORDS = HASH_BITS / CFG_DW;
  localparam int HI_W       = ADDR_W - CFG_DW;

  logic [CFG_DW-1:0] stn_lo;
  logic [HI_W-1:0]   stn_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= '0;
      stn_lo <= '0;
      stn_hi <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MODE) begin
        mode.promisc <= cfg_wdata[MODE_PROMISC];
        mode.uc_hash <= cfg_wdata[MODE_UC_HASH];
        mode.bc_rej  <= cfg_wdata[MODE_BC_REJ];
      end
      if (cfg_sel == SEL_STN_LO) stn_lo <= cfg_wdata;
      if (cfg_sel == SEL_STN_HI) stn_hi <= cfg_wdata[HI_W-1:0];
    end
  end

  // Byte 0 of the station lands in the top byte, matching the wire order of rx_da.
  assign station = {stn_hi, stn_lo};

  for (genvar g = 0; g < HASH_WORDS; g++) begin : g_hash
    logic [CFG_DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else if (cfg_we && cfg_sel == CFG_SELW'(int'(SEL_HASH0) + g)) word_q <= cfg_wdata;
    end
    assign hash_tbl[g*CFG_DW +: CFG_DW] = word_q;

    assert_hash_word_store_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_sel == CFG_SELW'(int'(SEL_HASH0) + g)) |=> (word_q == $past(cfg_wdata)));
  end

  assert_stn_lo_store_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_STN_LO) |=> (station[CFG_DW-1:0] == $past(cfg_wdata)));

  // R12: selects above the last hash word leave every register untouched.
  assert_unused_sel_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && int'(cfg_sel) >= int'(SEL_HASH0) + HASH_WORDS) |=>
      ($stable(station) && $stable(hash_tbl) && $stable(mode)));
endmodule

// File: rtl/rxf_addr_crc.sv
module rxf_addr_crc
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int NBYTES = ADDR_W / 8;

  logic [31:0] crc;

  always_comb begin
    crc = 32'hFFFF_FFFF;
    for (int k = 0; k < NBYTES; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (crc[31] ^ addr[ADDR_W-1-8*k-7+b])
          crc = {crc[30:0], 1'b0} ^ CRC_POLY;
        else
          crc = {crc[30:0], 1'b0};
      end
    end
  end

  assign idx = crc[31 -: IDX_W];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 64,
  parameter int IDX_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 da_valid,
  input  logic [ADDR_W-1:0]    da,
  input  logic [IDX_W-1:0]     idx,
  input  rxf_mode_t            mode,
  input  logic [ADDR_W-1:0]    station,
  input  logic [HASH_BITS-1:0] hash_tbl,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output rxf_reason_e          dec_reason
);
  localparam int GROUP_BIT = ADDR_W - 8;

  logic        is_bcast, is_mcast, exact_hit, hash_hit;
  rxf_reason_e rsn_d;

  assign is_bcast  = &da;
  assign is_mcast  = da[GROUP_BIT] && !is_bcast;
  assign exact_hit = !da[GROUP_BIT] && (da == station);
  assign hash_hit  = hash_tbl[idx];

  always_comb begin
    rsn_d = RSN_NONE;
    if (mode.promisc)                          rsn_d = RSN_PROMISC;
    else if (is_bcast)                         rsn_d = mode.bc_rej ? RSN_NONE : RSN_BCAST;
    else if (is_mcast)                         rsn_d = hash_hit ? RSN_HASH : RSN_NONE;
    else if (exact_hit)                        rsn_d = RSN_EXACT;
    else if (mode.uc_hash && hash_hit)         rsn_d = RSN_HASH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_NONE;
    end else begin
      dec_valid <= da_valid;
      if (da_valid) begin
        dec_accept <= (rsn_d != RSN_NONE);
        dec_reason <= rsn_d;
      end
    end
  end

  assert_accept_matches_reason_R11: assert property (@(posedge clk) disable iff (rst)
    dec_accept == (dec_reason != RSN_NONE));

  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (rst)
    (da_valid && mode.promisc) |=> (dec_valid && dec_accept && dec_reason == RSN_PROMISC));

  assert_bcast_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (da_valid && (&da) && mode.bc_rej && !mode.promisc) |=> (dec_valid && !dec_accept));

  assert_exact_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (da_valid && !mode.promisc && !da[GROUP_BIT] && da == station) |=> (dec_reason == RSN_EXACT));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (!da_valid) |=> !dec_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!da_valid) |=> $stable(dec_reason));
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [31:0]         cfg_wdata,
  input  logic                rx_da_valid,
  input  logic [ADDR_W-1:0]   rx_da,
  output logic                dec_valid,
  output logic                dec_accept,
  output logic [2:0]          dec_reason
);
  localparam int IDX_W = $clog2(HASH_BITS);

  rxf_mode_t             mode;
  logic [ADDR_W-1:0]     station;
  logic [HASH_BITS-1:0]  hash_tbl;
  logic [IDX_W-1:0]      idx;
  rxf_reason_e           reason;

  rxf_cfg_regs #(.HASH_BITS(HASH_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mode(mode), .station(station), .hash_tbl(hash_tbl)
  );

  rxf_addr_crc #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_crc (
    .addr(rx_da), .idx(idx)
  );

  rxf_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .da_valid(rx_da_valid), .da(rx_da), .idx(idx),
    .mode(mode), .station(station), .hash_tbl(hash_tbl),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(reason)
  );

  assign dec_reason = reason;
endmodule

// File: tb/tb_eth_rx_addr_filter.sv
module tb_eth_rx_addr_filter;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        rx_da_valid = 0;
  logic [47:0] rx_da = 0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Shadow copy of the registers, kept by the bench.
  logic [2:0]  s_mode;   // {promisc, uc_hash, bc_rej}
  logic [47:0] s_stn;
  logic [63:0] s_hash;

  always #10 clk = ~clk;

  eth_rx_addr_filter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_da_valid(rx_da_valid), .rx_da(rx_da),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  // Reflected CRC-32; the bit-reversed remainder gives the index.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] byt = a[47-8*k -: 8];
      for (int b = 0; b < 8; b++)
        r = (r[0] ^ byt[b]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic [2:0] ref_reason(input logic [47:0] a);
    logic hit = s_hash[ref_idx(a)];
    if (s_mode[2]) return 3'd4;
    if (a == '1) return s_mode[0] ? 3'd0 : 3'd3;
    if (a[40]) return hit ? 3'd2 : 3'd0;
    if (a == s_stn) return 3'd1;
    if (s_mode[1] && hit) return 3'd2;
    return 3'd0;
  endfunction

  function automatic void shadow_write(input logic [2:0] sel, input logic [31:0] d);
    case (sel)
      3'd0: s_mode = {d[5], d[4], d[3]};
      3'd1: s_stn[31:0] = d;
      3'd2: s_stn[47:32] = d[15:0];
      3'd3: s_hash[31:0] = d;
      3'd4: s_hash[63:32] = d;
      default: ;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    shadow_write(sel, d);
  endtask

  task automatic set_station(input logic [47:0] a);
    wr(3'd1, a[31:0]);
    wr(3'd2, {16'h0, a[47:32]});
  endtask

  // Sends one frame and checks the registered decision one edge later.
  task automatic send(input logic [47:0] a, input string req);
    logic [2:0] exp = ref_reason(a);
    @(negedge clk);
    rx_da_valid = 1; rx_da = a;
    @(negedge clk);
    rx_da_valid = 0;
    check(dec_valid === 1'b1, req, {31'h0, dec_valid}, 1);
    check(dec_reason === exp && dec_accept === (exp != 0), req,
          {28'h0, dec_accept, dec_reason}, {28'h0, exp != 3'd0, exp});
  endtask

  // R10: a write and a strobe on the same edge.
  task automatic send_with_write(input logic [47:0] a, input logic [2:0] sel,
                                 input logic [31:0] d, input string req);
    logic [2:0] exp = ref_reason(a);
    @(negedge clk);
    rx_da_valid = 1; rx_da = a;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    rx_da_valid = 0; cfg_we = 0;
    shadow_write(sel, d);
    check(dec_reason === exp, req, {29'h0, dec_reason}, {29'h0, exp});
  endtask

  function automatic logic [47:0] rnd_mcast_with_idx5(input bit want);
    logic [47:0] a;
    do begin
      a = {$urandom, $urandom};
      a[40] = 1'b1;
    end while (a == '1 || ref_idx(a)[5] != want);
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, stn;
    logic [5:0]  ix;
    void'($urandom(32'h1A2B3C));
    s_mode = 0; s_stn = 0; s_hash = 0;
    repeat (3) @(negedge clk);
    check(dec_valid === 0 && dec_accept === 0 && dec_reason === 0, "R1 in reset",
          {28'h0, dec_valid, dec_reason}, 0);
    rst = 0;
    @(negedge clk);
    check(dec_valid === 0 && dec_accept === 0 && dec_reason === 0, "R1 after reset",
          {28'h0, dec_valid, dec_reason}, 0);
    send(48'h0, "R1 zero station exact");
    @(negedge clk);
    check(dec_valid === 0, "R3 single pulse", {31'h0, dec_valid}, 0);
    check(dec_reason === 3'd1, "R3 held decision", {29'h0, dec_reason}, 1);

    stn = 48'h0A1B_2C3D_4E5F;
    set_station(stn);
    send(stn, "R4 exact hit R2 byte order");
    send({stn[47:8], ~stn[7:0]}, "R9 miss no hash");
    send(48'hFFFF_FFFF_FFFF, "R6 broadcast accepted");
    wr(3'd0, 32'h8);
    send(48'hFFFF_FFFF_FFFF, "R6 broadcast rejected");
    wr(3'd0, 32'h28);
    send(48'hFFFF_FFFF_FFFF, "R7 promisc over bc reject");
    send(48'h0200_0000_0001, "R7 promisc unicast");
    wr(3'd0, 32'h0);

    // R5: one multicast address per hash word.
    for (int w = 0; w < 2; w++) begin
      a = rnd_mcast_with_idx5(w[0]);
      ix = ref_idx(a);
      send(a, "R5 hash miss empty table");
      wr(3'd3 + 3'(w), 32'h1 << ix[4:0]);
      send(a, "R5 hash hit");
      wr(3'd3 + 3'(w), ~(32'h1 << ix[4:0]));
      send(a, "R5 other bits only");
      wr(3'd3 + 3'(w), 32'h0);
    end
    wr(3'd3, '1); wr(3'd4, '1);
    send(rnd_mcast_with_idx5(1'b0), "R5 all multicast");

    // R8 / R9: unicast miss against a full table.
    a = 48'h1234_5678_9ABC;
    send(a, "R9 uc_hash off");
    wr(3'd0, 32'h10);
    send(a, "R8 uc hash hit");
    send(stn, "R8 exact wins");

    // R12: unused selects.
    wr(3'd0, 32'h0); wr(3'd3, 0); wr(3'd4, 0);
    wr(3'd5, '1); wr(3'd6, '1); wr(3'd7, '1);
    send(stn, "R12 station kept");
    send(a, "R12 mode and table kept");
    send(rnd_mcast_with_idx5(1'b1), "R12 hash kept");

    // R10: collisions between a write and a strobe.
    send_with_write(a, 3'd0, 32'h20, "R10 promisc set same cycle");
    send(a, "R10 promisc next frame");
    send_with_write(48'hFFFF_FFFF_FFFF, 3'd0, 32'h8, "R10 bc reject same cycle");
    send(48'hFFFF_FFFF_FFFF, "R10 bc reject next frame");
    send_with_write(stn, 3'd1, 32'h0, "R10 station change same cycle");
    send(stn, "R10 station change next frame");
    a = rnd_mcast_with_idx5(1'b1);
    send_with_write(a, 3'd4, '1, "R10 hash set same cycle");
    send(a, "R10 hash next frame");

    // Random traffic.
    for (int i = 0; i < 400; i++) begin
      int kind = $urandom_range(0, 4);
      if (i % 20 == 0) begin
        wr(3'd0, $urandom & 32'h38);
        set_station({$urandom, $urandom} & 48'hFEFF_FFFF_FFFF);
        wr(3'd3, $urandom & $urandom);
        wr(3'd4, $urandom & $urandom);
      end
      case (kind)
        0: a = s_stn;
        1: a = '1;
        2: a = rnd_mcast_with_idx5(1'($urandom));
        default: begin a = {$urandom, $urandom}; a[40] = 1'b0; end
      endcase
      if (i % 7 == 3)
        send_with_write(a, 3'($urandom_range(0, 7)), $urandom, "R10 random collision R11");
      else
        send(a, "R11 random R4 R5 R6 R7 R8");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule